// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block derives the SCL waveform of an I2C master from a faster peripheral clock. A small configuration register holds a mode bit, a duty bit and a 12-bit divider. While the interface is enabled, the block counts peripheral clock cycles and alternates between a low phase and a high phase. The length of each phase is the divider multiplied by a factor that depends on the mode and the duty setting. Standard mode uses equal phases. Fast mode offers a 2:1 or a 16:9 low-to-high ratio. With the 16:9 ratio, an exact 400 kHz rate is reached when the peripheral clock is a multiple of 10 MHz.

The byte engine uses the `scl_low_req` output to pull SCL low, and uses the two single-cycle strobes to align data changes and sampling with the phase edges. The register accepts writes only while the interface is disabled. A divider of zero is treated as illegal, and SCL is left released while that value is loaded.

Top module: `scl_clkgen`

## Requirements
- R1: After reset the configuration is all zero, `scl_low_req` is 0, and both strobes are 0.
- R2: With the mode bit at 0 (standard), the low phase and the high phase each last D peripheral clock cycles, where D is the divider.
- R3: With the mode bit at 1 (fast) and the duty bit at 0, the low phase lasts 2·D cycles and the high phase lasts D cycles.
- R4: With the mode bit at 1 and the duty bit at 1, the low phase lasts 16·D cycles and the high phase lasts 9·D cycles.
- R5: In `cfg_wdata`, bit 15 is the mode bit, bit 14 is the duty bit and bits 11:0 are D. Bits 13:12 are reserved, and their value has no effect on the waveform.
- R6: A write with `cfg_we` high while `en` is 1 is ignored. The waveform keeps the previously stored configuration, including after a later disable and re-enable.
- R7: While D is 0, `scl_low_req` stays 0 and no strobe is produced, even with `en` at 1.
- R8: In the cycle after `en` is first sampled high with D nonzero, `scl_low_req` becomes 1 and `fall_stb` pulses. `fall_stb` is high only in the first cycle of each low phase, and `rise_stb` is high only in the first cycle of each high phase.
- R9: When `en` is sampled low, `scl_low_req` is 0 from the next cycle on. The next enable restarts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Interface enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data (mode, duty, divider) |
| scl_low_req | output | 1 | 1 requests that SCL be driven low |
| fall_stb | output | 1 | Pulses in the first cycle of a low phase |
| rise_stb | output | 1 | Pulses in the first cycle of a high phase |

## Verification
The case hardest to reach from the ports is a write that lands while the generator is running. Such a write must leave no trace, even after the interface has been turned off and on again. The stimulus first starts a standard-mode waveform. It then writes a different divider, with the fast bit set, in the middle of a phase. It measures one full period, toggles `en`, and measures again, expecting the original lengths both times. The 16:9 shape is measured over the longest phase, 16·D cycles, to check the multiply path.

// File: rtl/scl_pkg.sv
package scl_pkg;
   localparam int unsigned CFG_W    = 16;
   localparam int unsigned MODE_POS = 15;
   localparam int unsigned DUTY_POS = 14;
   localparam int unsigned LO_MUL_F = 2;
   localparam int unsigned LO_MUL_T = 16;
   localparam int unsigned HI_MUL_T = 9;
   typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
   parameter int unsigned DIV_W = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        we,
   input  logic [scl_pkg::CFG_W-1:0]   wdata,
   output logic                        fast,
   output logic                        duty,
   output logic [DIV_W-1:0]            div
);
   import scl_pkg::*;

   if (DIV_W > DUTY_POS - 2) begin : g_w_chk
      $error("DIV_W overlaps reserved bits");
   end

   logic take;
   assign take = we && !en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast <= 1'b0;
         duty <= 1'b0;
         div  <= '0;
      end else if (take) begin
         fast <= wdata[MODE_POS];
         duty <= wdata[DUTY_POS];
         div  <= wdata[DIV_W-1:0];
      end
   end

   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($stable(div) && $stable(fast) && $stable(duty)));
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
   parameter int unsigned DIV_W     = 12,
   parameter int unsigned CNT_W     = DIV_W + 4,
   parameter bit          USE_SHIFT = 1'b1
) (
   input  logic             fast,
   input  logic             duty,
   input  logic [DIV_W-1:0] div,
   output logic [CNT_W-1:0] len_lo,
   output logic [CNT_W-1:0] len_hi
);
   import scl_pkg::*;

   if (CNT_W < DIV_W + 4) begin : g_cw_chk
      $error("CNT_W too small for 16x divider");
   end

   logic [CNT_W-1:0] d1, d2, d9, d16;
   assign d1 = CNT_W'(div);

   if (USE_SHIFT) begin : g_shift
      assign d2  = d1 << 1;
      assign d16 = d1 << 4;
      assign d9  = (d1 << 3) + d1;
   end else begin : g_mul
      assign d2  = d1 * CNT_W'(LO_MUL_F);
      assign d16 = d1 * CNT_W'(LO_MUL_T);
      assign d9  = d1 * CNT_W'(HI_MUL_T);
   end

   always_comb begin
      if (!fast) begin
         len_lo = d1;
         len_hi = d1;
      end else if (!duty) begin
         len_lo = d2;
         len_hi = d1;
      end else begin
         len_lo = d16;
         len_hi = d9;
      end
   end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CNT_W-1:0] len_lo,
   input  logic [CNT_W-1:0] len_hi,
   output logic             low_req,
   output logic             fall_stb,
   output logic             rise_stb
);
   import scl_pkg::*;

   logic             run;
   phase_e           ph;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cur_len;
   logic             last;

   assign cur_len = (ph == PH_LOW) ? len_lo : len_hi;
   assign last    = (cnt == cur_len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         ph  <= PH_HIGH;
         cnt <= '0;
      end else if (!go) begin
         run <= 1'b0;
         ph  <= PH_HIGH;
         cnt <= '0;
      end else if (!run) begin
         run <= 1'b1;
         ph  <= PH_LOW;
         cnt <= '0;
      end else if (last) begin
         ph  <= (ph == PH_LOW) ? PH_HIGH : PH_LOW;
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign low_req  = run && (ph == PH_LOW);
   assign fall_stb = low_req && (cnt == '0);
   assign rise_stb = run && (ph == PH_HIGH) && (cnt == '0);

   // R8
   stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_stb, rise_stb}));
   // R8
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !run) |=> (low_req && fall_stb));
   // R9
   stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> !low_req);
   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < cur_len));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
   parameter int unsigned DIV_W     = 12,
   parameter bit          USE_SHIFT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   output logic        scl_low_req,
   output logic        fall_stb,
   output logic        rise_stb
);
   localparam int unsigned CNT_W = DIV_W + 4;

   logic             fast, duty;
   logic [DIV_W-1:0] div;
   logic [CNT_W-1:0] len_lo, len_hi;
   logic             go;

   scl_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .en(en), .we(cfg_we), .wdata(cfg_wdata),
      .fast(fast), .duty(duty), .div(div));

   scl_phase_len #(.DIV_W(DIV_W), .CNT_W(CNT_W), .USE_SHIFT(USE_SHIFT)) u_len (
      .fast(fast), .duty(duty), .div(div), .len_lo(len_lo), .len_hi(len_hi));

   assign go = en && (div != '0);

   scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .go(go), .len_lo(len_lo), .len_hi(len_hi),
      .low_req(scl_low_req), .fall_stb(fall_stb), .rise_stb(rise_stb));

   // R7
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0) |-> (!scl_low_req && !fall_stb && !rise_stb));
endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
   localparam time TCLK = 10ns;
   localparam int  NV   = 7;
   // {wdata, expected low, expected high}
   localparam logic [47:0] VEC [NV] = '{
      {16'h0005, 16'd5,  16'd5},   // R2
      {16'h0001, 16'd1,  16'd1},   // R2 minimum
      {16'h8003, 16'd6,  16'd3},   // R3
      {16'h8001, 16'd2,  16'd1},   // R3 minimum
      {16'hC002, 16'd32, 16'd18},  // R4
      {16'hC001, 16'd16, 16'd9},   // R4 minimum
      {16'h3004, 16'd4,  16'd4}    // R5 reserved bits set
   };

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic scl_low_req, fall_stb, rise_stb;
   int checks = 0, errors = 0;
   bit timeout = 1'b0;

   always #(TCLK/2) clk = ~clk;

   scl_clkgen u0 (.clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .scl_low_req(scl_low_req), .fall_stb(fall_stb),
      .rise_stb(rise_stb));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // measure one low phase and one high phase from the next fall strobe
   task automatic measure(output int lo, output int hi, output int rs);
      int g = 0;
      lo = 0; hi = 0; rs = 0;
      while (!fall_stb && g < 2000) begin @(negedge clk); g++; end
      while (scl_low_req && lo < 2000) begin lo++; @(negedge clk); end
      rs = rise_stb;
      while (!scl_low_req && hi < 2000) begin hi++; @(negedge clk); end
   endtask

   initial begin
      #(TCLK * 50000);
      timeout = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lo, hi, rs, seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 low_req", scl_low_req, 0);
      chk("R1 strobes", fall_stb | rise_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      en = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 div zero after reset", scl_low_req, 0);
      en = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk); en = 1'b0;
         wr(VEC[i][47:32]);
         en = 1'b1;
         measure(lo, hi, rs);
         chk($sformatf("R2/R3/R4/R5 vec%0d low", i), lo, int'(VEC[i][31:16]));
         chk($sformatf("R2/R3/R4/R5 vec%0d high", i), hi, int'(VEC[i][15:0]));
         chk($sformatf("R8 vec%0d rise strobe", i), rs, 1);
      end

      // R8 start timing and R9 release
      en = 1'b0; wr(16'h0004);
      en = 1'b1;
      @(negedge clk);
      chk("R8 low after enable", scl_low_req, 1);
      chk("R8 fall strobe first", fall_stb, 1);
      @(negedge clk);
      chk("R8 fall strobe single", fall_stb, 0);
      en = 1'b0;
      @(negedge clk);
      chk("R9 released after disable", scl_low_req, 0);
      en = 1'b1;
      @(negedge clk);
      lo = 0;
      while (scl_low_req && lo < 100) begin lo++; @(negedge clk); end
      chk("R9 full low on restart", lo, 4);

      // R6 write ignored while enabled
      en = 1'b0; wr(16'h0003);
      en = 1'b1;
      repeat (2) @(negedge clk);
      wr(16'h8007);
      measure(lo, hi, rs);
      chk("R6 low kept", lo, 3);
      chk("R6 high kept", hi, 3);
      en = 1'b0; @(negedge clk); @(negedge clk);
      en = 1'b1;
      measure(lo, hi, rs);
      chk("R6 low after re-enable", lo, 3);
      chk("R6 high after re-enable", hi, 3);

      // R7 divider zero held released
      en = 1'b0; wr(16'hC000);
      en = 1'b1;
      seen = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (scl_low_req || fall_stb || rise_stb) seen++;
      end
      chk("R7 zero divider released", seen, 0);
      en = 1'b0;

      if (!timeout) begin
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule